// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block turns a fast input clock into the timing that a multiplexed LCD panel needs. It produces a row shift clock, a one-line frame marker, a polarity-alternation level that flips every frame, and two non-overlapping phase clocks for the column driver chips.

A two-bit duty code sets the number of rows per frame to 48, 64, 96 or 128. A rate-select input matches the divider to one of two oscillator speeds, one twice the other, so the frame rate does not change with the speed. A mode input turns the generator on. When the mode input is low, the device is a follower in a multi-chip panel. Every output is then held low and the counters return to the start of a frame.

All outputs are decoded from registered counters. The duty code and the rate select may change while the generator runs. The counters end the current line or period cleanly when the new setting is shorter than the present position.

Top module: `lcd_frame_timing`

## Requirements
- R1: The number of shift-clock periods between consecutive frame-marker rises is 48, 64, 96 or 128 for duty_code 2'b00, 2'b01, 2'b10 or 2'b11 respectively (duty_code[1] is the first select bit).
- R2: One shift-clock period lasts PRESCALE input cycles when rate_sel is 0 and 2*PRESCALE cycles when rate_sel is 1. shift_clk is high for the first half of each period.
- R3: frame_start is high for exactly one shift-clock period, the first period (row 0) of each frame, and rises together with shift_clk.
- R4: ac_flip is 0 during the first frame after the generator is enabled. It inverts at the same edge on which frame_start rises for each later frame.
- R5: seg_ph1 is high for the first quarter of each shift-clock period. seg_ph2 is high for the quarter that starts at the middle of the period. The two are never high together.
- R6: One cycle after master_en is sampled low, every output is low and stays low. On re-enable, the first output cycle starts a new frame at row 0 with ac_flip at 0.
- R7: During reset, and after reset while master_en is low, every output is low.
- R8: If duty_code is shortened while the current row is at or beyond the new last row, the frame ends when that row's period ends. At that point frame_start rises and ac_flip inverts.
- R9: If rate_sel drops to 0 while the position within the period is at or past the shorter period's end, the period ends at the next edge and shift_clk rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | High: generate timing; low: follower, outputs held low |
| duty_code | input | 2 | Rows per frame: 00=48, 01=64, 10=96, 11=128 |
| rate_sel | input | 1 | 1 selects the doubled oscillator speed (divider doubled) |
| shift_clk | output | 1 | Row shift clock |
| frame_start | output | 1 | High for the whole first row of each frame |
| ac_flip | output | 1 | Polarity-alternation level, flips per frame |
| seg_ph1 | output | 1 | First column-driver phase clock |
| seg_ph2 | output | 1 | Second column-driver phase clock |

## Verification
Two events can land on the same clock edge. One is the frame wrap, where the row counter returns to zero and the alternation level flips. The other is a setting change that cuts short the current row or period. The bench provokes the first collision by switching from 128 rows to 48 rows while the generator is at row 100. It then requires the frame marker and the alternation flip exactly three cycles later, at the end of that row. The second collision is provoked by dropping the rate select at position five of an eight-cycle period. The bench requires the shift clock to rise on the very next sample, with the row already advanced past the frame marker.

// File: rtl/lcd_timing_pkg.sv
`timescale 1ns/1ps
package lcd_timing_pkg;
    // Row counter width: the largest frame has 128 rows.
    localparam int LINE_W = 7;

    typedef enum logic [1:0] {
        DUTY_48  = 2'b00,
        DUTY_64  = 2'b01,
        DUTY_96  = 2'b10,
        DUTY_128 = 2'b11
    } duty_e;

    // Index of the last row of a frame for a duty code.
    function automatic logic [LINE_W-1:0] last_row(input logic [1:0] code);
        case (duty_e'(code))
            DUTY_48:  last_row = LINE_W'(47);
            DUTY_64:  last_row = LINE_W'(63);
            DUTY_96:  last_row = LINE_W'(95);
            default:  last_row = LINE_W'(127);
        endcase
    endfunction
endpackage

// File: rtl/lcd_phase_div.sv
`timescale 1ns/1ps
module lcd_phase_div #(
    parameter  int PRESCALE = 4,
    localparam int PH_W     = $clog2(2*PRESCALE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            rate_sel,
    output logic [PH_W-1:0] phase,
    output logic [PH_W-1:0] half_len,
    output logic [PH_W-1:0] quarter_len,
    output logic            period_end
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [PH_W-1:0] last_pos;

    always_comb begin
        last_pos    = rate_sel ? PH_W'(2*PRESCALE-1) : PH_W'(PRESCALE-1);
        half_len    = rate_sel ? PH_W'(PRESCALE)     : PH_W'(PRESCALE/2);
        quarter_len = rate_sel ? PH_W'(PRESCALE/2)   : PH_W'(PRESCALE/4);
        // ">=" lets a shortened period end at once when rate_sel drops.
        period_end  = en && (st_q.ph >= last_pos);
        st_d        = st_q;
        if (!en || period_end) st_d.ph = '0;
        else                   st_d.ph = st_q.ph + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;

    // R9: the phase only steps by one or restarts at zero
    p_phase_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != $past(st_q.ph)) |-> (st_q.ph == '0 || st_q.ph == $past(st_q.ph) + PH_W'(1)));
endmodule

// File: rtl/lcd_line_seq.sv
`timescale 1ns/1ps
module lcd_line_seq
    import lcd_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              step,
    input  logic [1:0]        duty_code,
    output logic [LINE_W-1:0] row,
    output logic              ac
);
    typedef struct packed {
        logic [LINE_W-1:0] row;
        logic              ac;
    } row_state_t;

    row_state_t st_d, st_q;
    logic [LINE_W-1:0] row_last;

    always_comb begin
        row_last = last_row(duty_code);
        st_d     = st_q;
        if (!en) begin
            st_d = '0;
        end else if (step) begin
            // ">=" ends the frame at once when the duty code shrinks.
            if (st_q.row >= row_last) begin
                st_d.row = '0;
                st_d.ac  = ~st_q.ac;
            end else begin
                st_d.row = st_q.row + LINE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row = st_q.row;
    assign ac  = st_q.ac;

    // R1: rows advance by one or restart at zero
    p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.row != $past(st_q.row)) |-> (st_q.row == '0 || st_q.row == $past(st_q.row) + LINE_W'(1)));
    // R4: the alternation level changes only when row 0 begins
    p_ac_at_row0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ac != $past(st_q.ac)) |-> (st_q.row == '0));
endmodule

// File: rtl/lcd_phase_decode.sv
`timescale 1ns/1ps
module lcd_phase_decode
    import lcd_timing_pkg::*;
#(
    parameter int PH_W = 3
) (
    input  logic              en,
    input  logic [PH_W-1:0]   phase,
    input  logic [PH_W-1:0]   half_len,
    input  logic [PH_W-1:0]   quarter_len,
    input  logic [LINE_W-1:0] row,
    output logic              shift_hi,
    output logic              first_row,
    output logic              ph1,
    output logic              ph2
);
    logic [PH_W-1:0] ph2_end;

    always_comb begin
        ph2_end   = half_len + quarter_len;
        shift_hi  = en && (phase < half_len);
        first_row = en && (row == '0);
        ph1       = en && (phase < quarter_len);
        ph2       = en && (phase >= half_len) && (phase < ph2_end);
    end
endmodule

// File: rtl/lcd_frame_timing.sv
`timescale 1ns/1ps
module lcd_frame_timing
    import lcd_timing_pkg::*;
#(
    parameter  int PRESCALE = 4,
    localparam int PH_W     = $clog2(2*PRESCALE)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic [1:0] duty_code,
    input  logic       rate_sel,
    output logic       shift_clk,
    output logic       frame_start,
    output logic       ac_flip,
    output logic       seg_ph1,
    output logic       seg_ph2
);
    logic              en_d, en_q;
    logic [PH_W-1:0]   phase, half_len, quarter_len;
    logic              period_end;
    logic [LINE_W-1:0] row;
    logic              ac;

    always_comb en_d = master_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    lcd_phase_div #(.PRESCALE(PRESCALE)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en_q),
        .rate_sel    (rate_sel),
        .phase       (phase),
        .half_len    (half_len),
        .quarter_len (quarter_len),
        .period_end  (period_end)
    );

    lcd_line_seq u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .step      (period_end),
        .duty_code (duty_code),
        .row       (row),
        .ac        (ac)
    );

    lcd_phase_decode #(.PH_W(PH_W)) u_dec (
        .en          (en_q),
        .phase       (phase),
        .half_len    (half_len),
        .quarter_len (quarter_len),
        .row         (row),
        .shift_hi    (shift_clk),
        .first_row   (frame_start),
        .ph1         (seg_ph1),
        .ph2         (seg_ph2)
    );

    assign ac_flip = en_q && ac;

    // R5: the two phase clocks never overlap
    p_phase_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_ph1 && seg_ph2));
    // R5: first phase sits in the high half, second in the low half
    p_ph_halves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_ph1 |-> shift_clk) and (seg_ph2 |-> !shift_clk));
    // R6: a low mode input silences every output one cycle later
    p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!master_en) |-> !(shift_clk || frame_start || ac_flip || seg_ph1 || seg_ph2));
    // R3: the frame marker ends exactly where the next row's shift clock begins
    p_marker_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_start) && en_q) |-> $rose(shift_clk));
endmodule

// File: tb/lcd_frame_timing_test.sv
`timescale 1ns/1ps
module lcd_frame_timing_test;
    localparam int PRE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic [1:0] duty_code = 2'b00;
    logic       rate_sel = 1'b0;
    logic       shift_clk, frame_start, ac_flip, seg_ph1, seg_ph2;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lcd_frame_timing #(.PRESCALE(PRE)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en   (master_en),
        .duty_code   (duty_code),
        .rate_sel    (rate_sel),
        .shift_clk   (shift_clk),
        .frame_start (frame_start),
        .ac_flip     (ac_flip),
        .seg_ph1     (seg_ph1),
        .seg_ph2     (seg_ph2)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int outs_or();
        return int'(shift_clk | frame_start | ac_flip | seg_ph1 | seg_ph2);
    endfunction

    // Disable for two samples, then enable; returns on the first enabled sample.
    task automatic restart();
        @(negedge clk); master_en = 1'b0;
        @(negedge clk);
        @(negedge clk); master_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_frame_rise();
        bit prev;
        prev = 1'b1;
        while (!(frame_start && !prev)) begin
            prev = frame_start;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; master_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(outs_or() == 0, "R7 in reset", outs_or(), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(outs_or() == 0, "R7 after reset, follower", outs_or(), 0);
    endtask

    task automatic t_frame_len(input logic [1:0] code, input int rows);
        int gap, hi;
        bit prev, a0;
        duty_code = code; rate_sel = 1'b0;
        restart();
        chk(frame_start == 1'b1, "R3 marker on first enabled cycle", int'(frame_start), 1);
        a0 = ac_flip;
        chk(a0 == 1'b0, "R4 first frame level", int'(a0), 0);
        gap = 0; hi = 1; prev = 1'b1;
        forever begin
            @(negedge clk); gap++;
            if (frame_start && !prev) break;
            if (frame_start) hi++;
            prev = frame_start;
        end
        chk(gap == rows*PRE, "R1 frame length", gap, rows*PRE);
        chk(hi == PRE, "R3 marker width", hi, PRE);
        chk(ac_flip != a0, "R4 level inverts at frame", int'(ac_flip), int'(!a0));
    endtask

    task automatic t_shift_rate(input logic rs);
        int div, hi, p1, p2, ovl;
        div = rs ? 2*PRE : PRE;
        duty_code = 2'b00; rate_sel = rs;
        restart();
        chk(shift_clk && seg_ph1 && !seg_ph2, "R5 period opens with ph1", int'({shift_clk, seg_ph1, seg_ph2}), 6);
        hi = 0; p1 = 0; p2 = 0; ovl = 0;
        for (int k = 0; k < div; k++) begin
            if (k == div/2)
                chk(!shift_clk && seg_ph2, "R5 ph2 at mid period", int'({shift_clk, seg_ph2}), 1);
            hi  += int'(shift_clk);
            p1  += int'(seg_ph1);
            p2  += int'(seg_ph2);
            ovl += int'(seg_ph1 && seg_ph2);
            @(negedge clk);
        end
        chk(hi == div/2, "R2 high half", hi, div/2);
        chk(p1 == div/4, "R5 ph1 width", p1, div/4);
        chk(p2 == div/4, "R5 ph2 width", p2, div/4);
        chk(ovl == 0, "R5 overlap", ovl, 0);
        chk(shift_clk == 1'b1, "R2 period length", int'(shift_clk), 1);
    endtask

    task automatic t_slave();
        int busy;
        duty_code = 2'b00; rate_sel = 1'b0;
        restart();
        @(negedge clk);
        wait_frame_rise();
        chk(ac_flip == 1'b1, "R4 second frame level", int'(ac_flip), 1);
        repeat (10) @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        chk(outs_or() == 0, "R6 quiet one cycle after", outs_or(), 0);
        busy = 0;
        repeat (20) begin @(negedge clk); busy += outs_or(); end
        chk(busy == 0, "R6 stays quiet", busy, 0);
        master_en = 1'b1;
        @(negedge clk);
        chk(frame_start && shift_clk && !ac_flip, "R6 restart at row 0",
            int'({frame_start, shift_clk, ac_flip}), 6);
    endtask

    task automatic t_duty_shrink();
        int cnt;
        duty_code = 2'b11; rate_sel = 1'b0;
        restart();
        repeat (100*PRE + 1) @(negedge clk);
        duty_code = 2'b00;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!frame_start && cnt < 1000);
        chk(cnt == 3, "R8 frame ends at row end", cnt, 3);
        chk(ac_flip == 1'b1, "R8 level inverts", int'(ac_flip), 1);
    endtask

    task automatic t_rate_cut();
        int cnt;
        duty_code = 2'b00; rate_sel = 1'b1;
        restart();
        repeat (5) @(negedge clk);
        chk(shift_clk == 1'b0, "R9 low half before cut", int'(shift_clk), 0);
        rate_sel = 1'b0;
        @(negedge clk);
        chk(shift_clk && !frame_start, "R9 period cut short", int'({shift_clk, frame_start}), 2);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!(shift_clk && cnt > 1) && cnt < 100);
        chk(cnt == PRE, "R9 short period after cut", cnt, PRE);
    endtask

    initial begin
        t_reset();
        t_frame_len(2'b00, 48);
        t_frame_len(2'b01, 64);
        t_frame_len(2'b10, 96);
        t_frame_len(2'b11, 128);
        t_shift_rate(1'b0);
        t_shift_rate(1'b1);
        t_slave();
        t_duty_shrink();
        t_rate_cut();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule